// File: doc/BRIEF.md
# Pin Controller with Four-Condition Interrupt Capture

This block is a register-mapped controller for a bank of general-purpose pins, 16 by default, with bit n of every register belonging to pin n. Software sees a 32-bit word interface. Through it, software can read the synchronised input level and set the input enable, output enable, output level, output inversion, pull-up and drive-strength controls for each pin. It can also store the two alternate-function registers; the block keeps their values but does no multiplexing with them.

Each pin is watched for four conditions: rising edge, falling edge, high level and low level. Every condition has its own pending register and its own enable register. A pending bit latches its condition whether or not the matching enable is set. Software clears a pending bit by writing a one to that bit. Each pin drives its own level interrupt line towards a platform interrupt controller. The line is high while any condition of that pin is both pending and enabled, and stays high until software clears the pending bit or the enable bit. This makes the interrupt robust when the interrupt controller senses edges and a handler clears the pending bits before the interrupt source goes away.

Top module: `gpio_cond_irq`

## Requirements
- R1: After reset every control, enable and alternate-function register reads zero, and `irq`, `pin_out`, `pin_oe`, `pin_pull` and `pin_drive` are all zero.
- R2: The word offsets 0x04 (input enable), 0x08 (output enable), 0x0C (output level), 0x10 (pull-up), 0x14 (drive strength), 0x38 (alternate enable), 0x3C (alternate select) and 0x40 (output inversion) read back their last written value, with bits at and above N reading zero.
- R3: Offset 0x00 reads the pin input after a two-flop synchroniser, ANDed with the input enable. A change on `pin_in` shows up at the second rising clock edge after it is applied.
- R4: `pin_out` equals output level XOR output inversion. `pin_oe`, `pin_pull` and `pin_drive` follow their registers.
- R5: A pending bit latches whether or not its enable is set. Level conditions start from the third clock edge after reset is released and edge conditions from the fourth, so a pin that is high through reset shows high pending and no rise pending.
- R6: The four conditions are tracked independently. A low-to-high transition leaves rise and high pending alongside an earlier low pending, and a later high-to-low transition adds fall pending.
- R7: Writing to a pending register clears exactly the bits written as one. Bits written as zero, and the other pending registers, are unchanged.
- R8: If a condition is present in the same cycle as a write that clears its pending bit, the bit stays set.
- R9: `irq[n]` is the OR, over the four conditions, of pending AND enable for pin n. It does not fall unless a register write happened in the previous cycle.
- R10: Word offsets at and above 0x44 read zero, and writes to them change no register.
- R11: The enable and pending offsets are 0x18 and 0x1C for rise, 0x20 and 0x24 for fall, 0x28 and 0x2C for high, and 0x30 and 0x34 for low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | AW | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | N | Raw pin levels |
| pin_out | output | N | Output levels after inversion |
| pin_oe | output | N | Output driver enables |
| pin_pull | output | N | Pull-up enables |
| pin_drive | output | N | Drive-strength selects |
| irq | output | N | One level interrupt per pin |

## Verification
The pins are first held in a mixed idle pattern through reset. This separates real edge capture from false edges that an unsettled synchroniser would produce. Multi-pin input steps are then applied, and their rise set must match the pins that changed, which tells per-pin capture apart from a shared or shifted detector. A press-and-release sequence on one pin, with the pending bits cleared in the middle, shows that each condition is latched independently and that a clear during an active level does not win. A model reproduces every cycle of read data, pin outputs and interrupts throughout the run.

// File: rtl/gpio_cond_irq.sv
module gpio_cond_irq #(
  parameter int N  = 16,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic [N-1:0]  pin_pull,
  output logic [N-1:0]  pin_drive,
  output logic [N-1:0]  irq
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] W_IN   = IW'(0);
  localparam logic [IW-1:0] W_IEN  = IW'(1);
  localparam logic [IW-1:0] W_OEN  = IW'(2);
  localparam logic [IW-1:0] W_OUT  = IW'(3);
  localparam logic [IW-1:0] W_PULL = IW'(4);
  localparam logic [IW-1:0] W_DRV  = IW'(5);
  localparam logic [IW-1:0] W_AFE  = IW'(14);
  localparam logic [IW-1:0] W_AFS  = IW'(15);
  localparam logic [IW-1:0] W_XOR  = IW'(16);

  logic [IW-1:0] idx;
  logic [N-1:0]  wd;
  assign idx = bus_addr[AW-1:2];
  assign wd  = bus_wdata[N-1:0];

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  logic [N-1:0] in_en, out_en, out_val, pull, drv, af_en, af_sel, oxor;
  logic [N-1:0] ie [4];
  logic [N-1:0] ip [4];
  logic [N-1:0] cond [4];
  logic [N-1:0] s1, s2, prv;
  logic [1:0]   warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prv <= '0; warm <= '0;
    end else begin
      s1 <= pin_in; s2 <= s1; prv <= s2;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  always_comb begin
    cond[0] = (warm == 2'd3) ? (s2 & ~prv) : '0;
    cond[1] = (warm == 2'd3) ? (~s2 & prv) : '0;
    cond[2] = warm[1] ? s2  : '0;
    cond[3] = warm[1] ? ~s2 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en <= '0; out_en <= '0; out_val <= '0; pull <= '0;
      drv <= '0; af_en <= '0; af_sel <= '0; oxor <= '0;
    end else if (bus_wr) begin
      case (idx)
        W_IEN:  in_en   <= wd;
        W_OEN:  out_en  <= wd;
        W_OUT:  out_val <= wd;
        W_PULL: pull    <= wd;
        W_DRV:  drv     <= wd;
        W_AFE:  af_en   <= wd;
        W_AFS:  af_sel  <= wd;
        W_XOR:  oxor    <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        ie[c] <= '0;
        ip[c] <= '0;
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (bus_wr && idx == IW'(6 + 2*c)) ie[c] <= wd;
        ip[c] <= (ip[c] & ~((bus_wr && idx == IW'(7 + 2*c)) ? wd : '0)) | cond[c];
      end
    end
  end

  assign irq       = (ip[0] & ie[0]) | (ip[1] & ie[1]) | (ip[2] & ie[2]) | (ip[3] & ie[3]);
  assign pin_out   = out_val ^ oxor;
  assign pin_oe    = out_en;
  assign pin_pull  = pull;
  assign pin_drive = drv;

  logic [N-1:0] rd_n;
  always_comb begin
    rd_n = '0;
    case (idx)
      W_IN:   rd_n = s2 & in_en;
      W_IEN:  rd_n = in_en;
      W_OEN:  rd_n = out_en;
      W_OUT:  rd_n = out_val;
      W_PULL: rd_n = pull;
      W_DRV:  rd_n = drv;
      W_AFE:  rd_n = af_en;
      W_AFS:  rd_n = af_sel;
      W_XOR:  rd_n = oxor;
      default: ;
    endcase
    for (int c = 0; c < 4; c++) begin
      if (idx == IW'(6 + 2*c)) rd_n = ie[c];
      if (idx == IW'(7 + 2*c)) rd_n = ip[c];
    end
  end
  assign bus_rdata = 32'(rd_n);

  for (genvar g = 0; g < 4; g++) begin : g_pend_chk
    assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && idx == IW'(7 + 2*g)) |=> (($past(ip[g]) & ~ip[g]) == '0));
  end

  assert_high_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ip[2] & ~$past(ip[2]) & ~prv) == '0));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (($past(irq) & ~irq) == '0));

  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx > W_XOR) |-> (bus_rdata == 32'd0));

  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx > W_XOR) |=>
      $stable({in_en, out_en, out_val, pull, drv, af_en, af_sel, oxor,
               ie[0], ie[1], ie[2], ie[3]}));
endmodule

// File: tb/sim_gpio_cond_irq.sv
module sim_gpio_cond_irq;
  localparam int N = 16;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pin_in = 16'h0002;
  logic [N-1:0] pin_out, pin_oe, pin_pull, pin_drive, irq;
  int checks = 0, errors = 0;
  bit run = 0;

  always #5 clk = ~clk;

  gpio_cond_irq #(.N(N), .AW(7)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pull(pin_pull),
    .pin_drive(pin_drive), .irq(irq));

  logic [N-1:0] m_reg [0:16];
  logic [N-1:0] m_ie [4];
  logic [N-1:0] m_ip [4];
  logic [N-1:0] hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= 16; i++) m_reg[i] = '0;
      for (int c = 0; c < 4; c++) begin m_ie[c] = '0; m_ip[c] = '0; end
      hist.delete();
    end else begin
      logic [N-1:0] st [4];
      int w;
      for (int c = 0; c < 4; c++) st[c] = '0;
      if (hist.size() >= 2) begin
        st[2] = hist[1];
        st[3] = ~hist[1];
      end
      if (hist.size() >= 3) begin
        st[0] = hist[1] & ~hist[2];
        st[1] = ~hist[1] & hist[2];
      end
      w = int'(bus_addr[6:2]);
      for (int c = 0; c < 4; c++) begin
        if (bus_wr && w == 7 + 2*c) m_ip[c] = m_ip[c] & ~bus_wdata[N-1:0];
        m_ip[c] = m_ip[c] | st[c];
        if (bus_wr && w == 6 + 2*c) m_ie[c] = bus_wdata[N-1:0];
      end
      if (bus_wr && ((w >= 1 && w <= 5) || (w >= 14 && w <= 16)))
        m_reg[w] = bus_wdata[N-1:0];
      hist.push_front(pin_in);
      if (hist.size() > 3) void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] m_rd(logic [6:0] a);
    int w = int'(a[6:2]);
    logic [N-1:0] v = '0;
    if (w == 0) v = (hist.size() >= 2 ? hist[1] : '0) & m_reg[1];
    else if ((w >= 1 && w <= 5) || (w >= 14 && w <= 16)) v = m_reg[w];
    else if (w >= 6 && w <= 13) v = (w % 2 == 0) ? m_ie[(w-6)/2] : m_ip[(w-7)/2];
    return 32'(v);
  endfunction

  function automatic logic [N-1:0] m_irq();
    return (m_ip[0] & m_ie[0]) | (m_ip[1] & m_ie[1]) | (m_ip[2] & m_ie[2]) | (m_ip[3] & m_ie[3]);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (run) begin
      int w = int'(bus_addr[6:2]);
      string t = (w == 0) ? "R3 read" : (w >= 6 && w <= 13) ? "R11 read" :
                 (w > 16) ? "R10 read" : "R2 read";
      chk(t, bus_rdata, m_rd(bus_addr));
      chk("R9 irq", 32'(irq), 32'(m_irq()));
      chk("R4 pin_out", 32'(pin_out), 32'(m_reg[3] ^ m_reg[16]));
      chk("R4 pin_oe/pull/drive", {pin_oe, pin_pull[7:0], pin_drive[7:0]},
          {m_reg[2], m_reg[4][7:0], m_reg[5][7:0]});
    end
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #3 v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    run = 1;
    idle(1);
    chk("R1 irq in reset", 32'(irq), 0);
    rst_n = 1;
    idle(5);
    rd(7'h04, v); chk("R1 input enable after reset", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pin_out", 32'(pin_out), 0);
    rd(7'h2C, v); chk("R5 high pending with enable clear", v, 32'h0002);
    rd(7'h34, v); chk("R5 low pending on idle-low pins", v, 32'hFFFD);
    rd(7'h1C, v); chk("R5 no rise from reset release", v, 0);
    wr(7'h30, 32'h0002);
    idle(1); chk("R9 low enable but no low pending", 32'(irq), 0);
    wr(7'h04, 32'hFFFF_FFFF);
    rd(7'h04, v); chk("R2 upper bits read zero", v, 32'h0000_FFFF);
    wr(7'h3C, 32'h00A5);
    rd(7'h3C, v); chk("R2 alternate select", v, 32'h00A5);
    pin_in = 16'h1236;
    idle(4);
    rd(7'h00, v); chk("R3 input value", v, 32'h1236);
    rd(7'h1C, v); chk("R11 rise pending per pin", v, 32'h1234);
    wr(7'h04, 32'h00FF);
    rd(7'h00, v); chk("R3 input enable mask", v, 32'h0036);
    wr(7'h0C, 32'h00F0);
    wr(7'h40, 32'h0F00);
    idle(1); chk("R4 output xor", 32'(pin_out), 32'h0FF0);
    wr(7'h08, 32'h1111);
    idle(1); chk("R4 output enable", 32'(pin_oe), 32'h1111);
    wr(7'h44, 32'hFFFF);
    rd(7'h44, v); chk("R10 unmapped read", v, 0);
    rd(7'h7C, v); chk("R10 top word read", v, 0);
    rd(7'h0C, v); chk("R10 write ignored", v, 32'h00F0);
    pin_in = 16'h1234;
    idle(4);
    chk("R9 low pending and enabled", 32'(irq & 16'h0002), 32'h0002);
    wr(7'h1C, 32'h0002); wr(7'h24, 32'h0002);
    wr(7'h2C, 32'h0002); wr(7'h34, 32'h0002);
    rd(7'h34, v); chk("R8 set wins over clear", v & 32'h2, 32'h2);
    rd(7'h24, v); chk("R7 fall cleared", v & 32'h2, 0);
    pin_in = 16'h1236;
    idle(4);
    rd(7'h1C, v); chk("R6 rise after pulse", v & 32'h2, 32'h2);
    rd(7'h24, v); chk("R6 no fall yet", v & 32'h2, 0);
    rd(7'h2C, v); chk("R6 high after pulse", v & 32'h2, 32'h2);
    rd(7'h34, v); chk("R6 low kept", v & 32'h2, 32'h2);
    pin_in = 16'h1234;
    idle(4);
    rd(7'h24, v); chk("R6 fall added", v & 32'h2, 32'h2);
    idle(5);
    chk("R9 irq held as level", 32'(irq & 16'h0002), 32'h0002);
    wr(7'h30, 32'h0);
    idle(1); chk("R9 enable clear drops irq", 32'(irq & 16'h0002), 0);
    wr(7'h1C, 32'h0002);
    rd(7'h1C, v); chk("R7 rise cleared", v & 32'h2, 0);
    rd(7'h2C, v); chk("R7 high untouched", v & 32'h2, 32'h2);
    wr(7'h2C, 32'h0);
    rd(7'h2C, v); chk("R7 zero write no effect", v & 32'h2, 32'h2);
    wr(7'h28, 32'h0002);
    idle(1); chk("R9 high enable raises irq", 32'(irq & 16'h0002), 32'h0002);
    rd(7'h28, v); chk("R11 high enable offset", v, 32'h0002);
    rd(7'h30, v); chk("R11 low enable offset", v, 0);
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule